// File: doc/BRIEF.md
# Latched Time-Match Alarm Unit

This block watches the running calendar clock and raises an alarm when the current time agrees with a set of programmed alarm values. It holds seven alarm threshold registers, one for each BCD time or calendar field, and one configuration register. Software sets them through a simple register port. The timekeeper supplies the live fields as one flat bus, together with a one-cycle strobe that pulses once per second.

The configuration register chooses which fields take part in the comparison and carries a global enable. The unit checks for a match only on the one-second strobe. A match pulls the active-low alarm output low, and the output stays low until software touches any alarm register, by reading it or by writing it. The open-drain pad and the serial bus decoder lie outside this block.

Top module: `time_alarm_unit`

## Requirements
- R1: After a synchronous reset, `alarm_n` is 1, `reg_rdata` is 0, and every threshold and the configuration register read back as 0.
- R2: A write with `reg_access`=1 and `reg_write`=1 stores `reg_wdata`. Addresses 0..6 select threshold fields 0..6 and address 7 selects the configuration register. A read with `reg_access`=1 and `reg_write`=0 presents that register on `reg_rdata` one cycle later.
- R3: When `tick`=1, configuration bit 7 is 1, and every unmasked field i equals threshold i, `alarm_n` is 0 from the next cycle. Field i occupies bits [8i+7:8i] of `time_fields`. The comparison uses the register values held before any write made in the same cycle.
- R4: Configuration bit i (0..6) set to 1 masks field i, so that field always counts as matching.
- R5: While configuration bit 7 is 0, no alarm is latched.
- R6: No alarm is latched in a cycle where `tick` is 0, even if the fields match.
- R7: Once `alarm_n` is low, it stays low while no register access occurs, even when the time moves on.
- R8: Any read or write of addresses 0..7 drives `alarm_n` back to 1 in the next cycle, unless R9 applies.
- R9: When a clearing access and a set condition occur in the same cycle, the set wins and `alarm_n` is 0 in the next cycle.
- R10: `reg_rdata` keeps its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second strobe, one cycle wide |
| time_fields | input | 56 | Live BCD fields, field i at bits [8i+7:8i] |
| reg_access | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| alarm_n | output | 1 | Registered active-low alarm |

## Verification
Both results are due one clock edge after the stimulus that causes them. An alarm set or clear appears on `alarm_n`, and read data appears on `reg_rdata`, after the single edge that follows the cycle in which `tick` or the access was presented. The bench drives every input on the falling edge. It advances the model and the design by one rising edge, then compares both outputs on the next falling edge. Same-cycle collisions of tick, clear and write are therefore compared against the model's pre-write state, which is exactly what R3 and R9 require.

// File: rtl/tau_pkg.sv
package tau_pkg;
  localparam int DEF_FIELDS  = 7;
  localparam int DEF_FIELD_W = 8;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_SET   = 2'd2
  } alarm_act_e;
endpackage

// File: rtl/tau_regfile.sv
module tau_regfile #(
  parameter int NUM_FIELDS = 7,
  parameter int FIELD_W    = 8,
  parameter int ADDR_W     = $clog2(NUM_FIELDS + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_access,
  input  logic                          reg_write,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [FIELD_W-1:0]            reg_wdata,
  output logic [FIELD_W-1:0]            reg_rdata,
  output logic [NUM_FIELDS*FIELD_W-1:0] thr_flat,
  output logic [FIELD_W-1:0]            cfg,
  output logic                          hit_any
);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NUM_FIELDS);

  logic [FIELD_W-1:0] thr_q [NUM_FIELDS];
  logic [FIELD_W-1:0] cfg_q;
  logic [FIELD_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (reg_addr == ADDR_W'(i)) rd_mux = thr_q[i];
    if (reg_addr == CFG_ADDR) rd_mux = cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      reg_rdata <= '0;
    end else if (reg_access) begin
      if (reg_write) begin
        if (reg_addr == CFG_ADDR) cfg_q <= reg_wdata;
      end else begin
        reg_rdata <= rd_mux;
      end
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) thr_q[g] <= '0;
      else if (reg_access && reg_write && reg_addr == ADDR_W'(g))
        thr_q[g] <= reg_wdata;
    end
    assign thr_flat[g*FIELD_W +: FIELD_W] = thr_q[g];
  end

  assign cfg     = cfg_q;
  assign hit_any = reg_access && (reg_addr <= CFG_ADDR);
endmodule

// File: rtl/tau_match.sv
module tau_match #(
  parameter int NUM_FIELDS = 7,
  parameter int FIELD_W    = 8
) (
  input  logic [NUM_FIELDS*FIELD_W-1:0] now_flat,
  input  logic [NUM_FIELDS*FIELD_W-1:0] thr_flat,
  input  logic [NUM_FIELDS-1:0]         mask,
  output logic                          all_match
);
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    assign fld_ok[g] = mask[g] ||
      (now_flat[g*FIELD_W +: FIELD_W] == thr_flat[g*FIELD_W +: FIELD_W]);
  end

  assign all_match = &fld_ok;
endmodule

// File: rtl/tau_latch.sv
module tau_latch
  import tau_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_evt,
  output logic alarm_n
);
  alarm_act_e act;

  always_comb begin
    if (set_evt)      act = ACT_SET;
    else if (clr_evt) act = ACT_CLEAR;
    else              act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) alarm_n <= 1'b1;
    else begin
      case (act)
        ACT_SET:   alarm_n <= 1'b0;
        ACT_CLEAR: alarm_n <= 1'b1;
        default:   alarm_n <= alarm_n;
      endcase
    end
  end
endmodule

// File: rtl/time_alarm_unit.sv
module time_alarm_unit #(
  parameter int NUM_FIELDS = tau_pkg::DEF_FIELDS,
  parameter int FIELD_W    = tau_pkg::DEF_FIELD_W,
  parameter int ADDR_W     = $clog2(NUM_FIELDS + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  input  logic [NUM_FIELDS*FIELD_W-1:0] time_fields,
  input  logic                          reg_access,
  input  logic                          reg_write,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [FIELD_W-1:0]            reg_wdata,
  output logic [FIELD_W-1:0]            reg_rdata,
  output logic                          alarm_n
);
  localparam int EN_BIT = FIELD_W - 1;

  logic [NUM_FIELDS*FIELD_W-1:0] thr_flat;
  logic [FIELD_W-1:0]            cfg;
  logic                          hit_any;
  logic                          all_match;
  logic                          alarm_enable;
  logic                          set_evt;

  tau_regfile #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_access(reg_access), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .thr_flat(thr_flat), .cfg(cfg), .hit_any(hit_any)
  );

  tau_match #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_match (
    .now_flat(time_fields), .thr_flat(thr_flat),
    .mask(cfg[NUM_FIELDS-1:0]), .all_match(all_match)
  );

  assign alarm_enable = cfg[EN_BIT];
  assign set_evt      = tick && alarm_enable && all_match;

  tau_latch u_latch (
    .clk(clk), .rst(rst), .set_evt(set_evt), .clr_evt(hit_any), .alarm_n(alarm_n)
  );
endmodule

// File: rtl/tau_chk.sv
module tau_chk #(
  parameter int NUM_FIELDS = 7,
  parameter int FIELD_W    = 8,
  parameter int ADDR_W     = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               reg_access,
  input logic               reg_write,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [FIELD_W-1:0] reg_rdata,
  input logic               alarm_n,
  input logic               alarm_enable
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_FIELDS);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (alarm_n && reg_rdata == '0));

  p_no_set_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    (alarm_n && !alarm_enable) |=> alarm_n);

  p_no_set_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (alarm_n && !tick) |=> alarm_n);

  p_sticky_low_r7: assert property (@(posedge clk) disable iff (rst)
    (!alarm_n && !reg_access) |=> !alarm_n);

  p_clear_release_r8: assert property (@(posedge clk) disable iff (rst)
    (!alarm_n && reg_access && reg_addr <= TOP_ADDR && !tick) |=> alarm_n);

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(reg_access && !reg_write) |=> $stable(reg_rdata));
endmodule

bind time_alarm_unit tau_chk #(
  .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)
) u_tau_chk (
  .clk(clk), .rst(rst), .tick(tick), .reg_access(reg_access),
  .reg_write(reg_write), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .alarm_n(alarm_n), .alarm_enable(alarm_enable)
);

// File: tb/test_time_alarm_unit.sv
module test_time_alarm_unit;
  localparam int NF = 7;
  localparam int FW = 8;
  localparam int AW = 3;

  logic clk = 0;
  logic rst = 1;
  logic tick = 0;
  logic [NF*FW-1:0] time_fields = '0;
  logic reg_access = 0, reg_write = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [FW-1:0] reg_wdata = '0;
  logic [FW-1:0] reg_rdata;
  logic alarm_n;

  int total = 0, bad = 0;
  bit done = 0;

  logic [FW-1:0] m_thr [NF];
  logic [FW-1:0] m_cfg = '0;
  logic [FW-1:0] m_rd = '0;
  logic          m_alarm_n = 1'b1;

  time_alarm_unit i_time_alarm_unit (
    .clk(clk), .rst(rst), .tick(tick), .time_fields(time_fields),
    .reg_access(reg_access), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_n(alarm_n)
  );

  always #5 clk = ~clk;

  function automatic bit ref_match(input logic [NF*FW-1:0] tm);
    bit ok = 1;
    for (int i = 0; i < NF; i++)
      if (!m_cfg[i] && tm[i*FW +: FW] != m_thr[i]) ok = 0;
    return ok;
  endfunction

  function automatic logic [NF*FW-1:0] thr_as_time();
    logic [NF*FW-1:0] t;
    for (int i = 0; i < NF; i++) t[i*FW +: FW] = m_thr[i];
    return t;
  endfunction

  task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit tk, input bit acc, input bit wr, input int ad,
                      input logic [FW-1:0] wd, input logic [NF*FW-1:0] tm, input string req);
    bit set, clr;
    string rq;
    tick = tk; reg_access = acc; reg_write = wr; reg_addr = AW'(ad);
    reg_wdata = wd; time_fields = tm;
    set = tk && m_cfg[FW-1] && ref_match(tm);
    clr = acc && ad <= NF;
    if (set) m_alarm_n = 1'b0;
    else if (clr) m_alarm_n = 1'b1;
    if (acc && wr) begin
      if (ad < NF) m_thr[ad] = wd;
      else if (ad == NF) m_cfg = wd;
    end else if (acc) begin
      m_rd = (ad < NF) ? m_thr[ad] : ((ad == NF) ? m_cfg : '0);
    end
    @(negedge clk);
    rq = (req != "") ? req : (set ? "R3" : (clr ? "R8" : "R7"));
    check(rq, {7'd0, alarm_n}, {7'd0, m_alarm_n});
    check((acc && !wr) ? "R2" : "R10", reg_rdata, m_rd);
    tick = 0; reg_access = 0;
  endtask

  task automatic idle(input int n, input logic [NF*FW-1:0] tm);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, '0, tm, "R7");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NF*FW-1:0] hit, miss;
    void'($urandom(32'd20250417));
    for (int i = 0; i < NF; i++) m_thr[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1", {7'd0, alarm_n}, 8'h01);
    check("R1", reg_rdata, 8'h00);
    for (int a = 0; a <= NF; a++) step(0, 1, 0, a, '0, '0, "R1");

    // R2: program thresholds and config, read back
    begin
      logic [FW-1:0] vals [NF] = '{8'h30, 8'h45, 8'h12, 8'h03, 8'h21, 8'h06, 8'h24};
      for (int i = 0; i < NF; i++) step(0, 1, 1, i, vals[i], '0, "R2");
    end
    step(0, 1, 1, NF, 8'h80, '0, "R2");
    for (int a = 0; a <= NF; a++) step(0, 1, 0, a, '0, '0, "R2");

    hit = thr_as_time();
    miss = hit; miss[7:0] = 8'h31;

    // R3: mismatch then match
    step(1, 0, 0, 0, '0, miss, "R3");
    step(1, 0, 0, 0, '0, hit, "R3");
    check("R3", {7'd0, alarm_n}, 8'h00);
    // R7: sticky through idle time
    idle(5, miss);
    check("R7", {7'd0, alarm_n}, 8'h00);
    // R8: read config clears
    step(0, 1, 0, NF, '0, miss, "R8");
    check("R8", {7'd0, alarm_n}, 8'h01);

    // R6: match without tick
    step(0, 0, 0, 0, '0, hit, "R6");
    step(0, 0, 0, 0, '0, hit, "R6");

    // R5: disabled
    step(0, 1, 1, NF, 8'h00, hit, "R5");
    step(1, 0, 0, 0, '0, hit, "R5");
    check("R5", {7'd0, alarm_n}, 8'h01);

    // R4: mask seconds field
    step(0, 1, 1, NF, 8'h81, hit, "R4");
    step(1, 0, 0, 0, '0, miss, "R4");
    check("R4", {7'd0, alarm_n}, 8'h00);
    // R8: write threshold clears
    step(0, 1, 1, 3, 8'h03, miss, "R8");
    check("R8", {7'd0, alarm_n}, 8'h01);

    // R9: set and clear together, from high and from low
    step(1, 1, 0, 2, '0, hit, "R9");
    check("R9", {7'd0, alarm_n}, 8'h00);
    step(1, 1, 1, 5, 8'h06, hit, "R9");
    check("R9", {7'd0, alarm_n}, 8'h00);
    step(0, 1, 0, 0, '0, hit, "R8");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [NF*FW-1:0] tm;
      bit acc, wr;
      int ad;
      logic [FW-1:0] wd;
      tm = thr_as_time();
      if ($urandom_range(0, 3) == 0) tm[$urandom_range(0, NF-1)*FW +: FW] = FW'($urandom);
      acc = ($urandom_range(0, 9) == 0);
      wr  = $urandom_range(0, 1);
      ad  = $urandom_range(0, NF);
      wd  = FW'($urandom);
      if (ad == NF) wd = {$urandom_range(0, 3) != 0, 7'($urandom) & 7'h03};
      if (ad < NF && $urandom_range(0, 1) == 1) wd = m_thr[ad];
      step($urandom_range(0, 2) == 0, acc, wr, ad, wd, tm, "");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule